// File: doc/BRIEF.md
# CAN Transmitter Fail-Safe Supervisor

This block sits between a microcontroller and a high-speed CAN line driver. It takes the controller's transmit data line and a run/sleep request. It produces three outputs: the enable for the line driver, the gated dominant-drive command, and a link-ready status that tells the controller when frames can be sent and received.

After the run request rises, the block waits out a start-up period before it enables the driver. While the driver is enabled, it counts how many cycles in a row the transmit line stays dominant. If that run reaches a limit, the block drops the driver enable, so the bus falls back to recessive. The enable stays off until the transmit line is seen recessive again. The link-ready status is low during start-up, after a timeout, and whenever either supply-undervoltage flag is raised. The timeout must be set longer than the longest legal dominant run at the slowest supported bit rate (15 kbit/s).

Top module: `can_tx_failsafe`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `drv_en_o`, `link_ready_o` and `tx_dom_o` are all 0.
- R2: `run_req_i` = 0 requests sleep and 1 requests normal operation. When 0 is sampled at a clock edge, `drv_en_o` and `link_ready_o` are 0 from that edge on. A floating run request must be resolved to 0 outside this block.
- R3: Start-up: `drv_en_o` becomes 1 only after `run_req_i` has been sampled 1 on STARTUP_CYC+1 consecutive edges. It rises right after the last of those edges, provided no timeout is latched.
- R4: `txd_i` = 1 means recessive and 0 means dominant. `tx_dom_o` is 1 exactly when `drv_en_o` is 1 and `txd_i` is 0. A floating transmit line must be resolved to 1 outside this block.
- R5: While the driver is ready, each edge that samples `txd_i` = 0 extends the dominant run. An edge that samples 1 clears the run. The edge that samples the TIMEOUT_CYC-th consecutive 0 latches a timeout, and `drv_en_o` is 0 after that edge.
- R6: A latched timeout holds `drv_en_o` at 0 until an edge samples `txd_i` = 1. The enable returns right after that edge if the block is still ready. The dominant-run counter saturates and never wraps.
- R7: `link_ready_o` is 1 only when `drv_en_o` is 1 and both `uv_io_i` and `uv_buf_i` are 0. Either flag forces the output to 0 in the same cycle.
- R8: Dominant samples taken while the block is asleep or starting up do not add to the dominant run. Counting starts only once the driver is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req_i | input | 1 | 1 requests normal operation, 0 requests sleep |
| txd_i | input | 1 | Transmit data from the controller, 0 = dominant |
| uv_io_i | input | 1 | Undervoltage flag for the I/O supply |
| uv_buf_i | input | 1 | Undervoltage flag for the buffer supply |
| drv_en_o | output | 1 | Line driver enable |
| tx_dom_o | output | 1 | Command to drive the bus dominant |
| link_ready_o | output | 1 | Status: the link can send and receive |

## Verification
The assertions assume all inputs are synchronous to `clk` and already resolved to 0 or 1. They also assume the undervoltage flags act only through the status gating. The stimulus changes every input just after the falling edge, so each rising edge samples stable values. Random transmit runs of 1 to 20 cycles cross the timeout limit of 12 cycles used in the bench. Run-request and undervoltage toggles are rare enough that long ready stretches occur, while start-up entries and exits still happen many times.

// File: rtl/can_tx_failsafe_pkg.sv
package can_tx_failsafe_pkg;
  typedef enum logic [1:0] {
    PH_SLEEP   = 2'd0,
    PH_STARTUP = 2'd1,
    PH_READY   = 2'd2
  } phase_e;
endpackage

// File: rtl/fsf_mode_seq.sv
module fsf_mode_seq
  import can_tx_failsafe_pkg::*;
#(
  parameter int STARTUP_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req_i,
  output logic ready_o
);
  localparam int SW = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
  localparam logic [SW-1:0] LAST = SW'(STARTUP_CYC - 1);

  phase_e        phase_q;
  logic [SW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SLEEP;
      wait_q  <= '0;
    end else if (!run_req_i) begin
      phase_q <= PH_SLEEP;
      wait_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_SLEEP: begin
          phase_q <= PH_STARTUP;
          wait_q  <= '0;
        end
        PH_STARTUP: begin
          if (wait_q == LAST) phase_q <= PH_READY;
          else                wait_q  <= wait_q + 1'b1;
        end
        default: phase_q <= PH_READY;
      endcase
    end
  end

  assign ready_o = (phase_q == PH_READY);
endmodule

// File: rtl/fsf_dom_timer.sv
module fsf_dom_timer #(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic txd_i,
  output logic tripped_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] TRIP_AT = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] SAT     = CW'(TIMEOUT_CYC);

  logic [CW-1:0] run_q;
  logic          trip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      trip_q <= 1'b0;
    end else if (txd_i) begin
      run_q  <= '0;
      trip_q <= 1'b0;
    end else if (arm_i) begin
      if (run_q == TRIP_AT) trip_q <= 1'b1;
      if (run_q != SAT)     run_q  <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  assign tripped_o = trip_q;
endmodule

// File: rtl/can_tx_failsafe.sv
module can_tx_failsafe #(
  parameter int STARTUP_CYC = 16,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req_i,
  input  logic txd_i,
  input  logic uv_io_i,
  input  logic uv_buf_i,
  output logic drv_en_o,
  output logic tx_dom_o,
  output logic link_ready_o
);
  logic ready;
  logic tripped;

  fsf_mode_seq #(.STARTUP_CYC(STARTUP_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_req_i (run_req_i),
    .ready_o   (ready)
  );

  fsf_dom_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (ready),
    .txd_i     (txd_i),
    .tripped_o (tripped)
  );

  assign drv_en_o     = ready & ~tripped;
  assign tx_dom_o     = drv_en_o & ~txd_i;
  assign link_ready_o = drv_en_o & ~uv_io_i & ~uv_buf_i;
endmodule

// File: rtl/can_tx_failsafe_chk.sv
module can_tx_failsafe_chk #(
  parameter int TIMEOUT_CYC = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic run_req_i,
  input logic txd_i,
  input logic uv_io_i,
  input logic uv_buf_i,
  input logic drv_en_o,
  input logic tx_dom_o,
  input logic link_ready_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 2);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] dom_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 dom_run <= '0;
    else if (drv_en_o && !txd_i) dom_run <= (dom_run == CMAX) ? dom_run : dom_run + 1'b1;
    else                         dom_run <= '0;
  end

  // R2
  sleep_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_req_i |=> (!drv_en_o && !link_ready_o));

  // R3
  startup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_req_i) |=> !drv_en_o);

  // R4
  dom_needs_low_txd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dom_o |-> (!txd_i && drv_en_o));

  // R5
  dom_run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dom_run <= CW'(TIMEOUT_CYC));

  // R7
  uv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_io_i || uv_buf_i) |-> !link_ready_o);

  // R7
  ready_needs_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready_o |-> drv_en_o);
endmodule

bind can_tx_failsafe can_tx_failsafe_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_req_i    (run_req_i),
  .txd_i        (txd_i),
  .uv_io_i      (uv_io_i),
  .uv_buf_i     (uv_buf_i),
  .drv_en_o     (drv_en_o),
  .tx_dom_o     (tx_dom_o),
  .link_ready_o (link_ready_o)
);

// File: tb/can_tx_failsafe_test.sv
`timescale 1ns/1ps
module can_tx_failsafe_test;
  localparam int S = 5;
  localparam int T = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_req_i = 1'b0;
  logic txd_i = 1'b1;
  logic uv_io_i = 1'b0;
  logic uv_buf_i = 1'b0;
  logic drv_en_o, tx_dom_o, link_ready_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_tx_failsafe #(.STARTUP_CYC(S), .TIMEOUT_CYC(T)) uut (
    .clk(clk), .rst_n(rst_n), .run_req_i(run_req_i), .txd_i(txd_i),
    .uv_io_i(uv_io_i), .uv_buf_i(uv_buf_i),
    .drv_en_o(drv_en_o), .tx_dom_o(tx_dom_o), .link_ready_o(link_ready_o)
  );

  // Requirement-level model: consecutive run-request samples and
  // consecutive dominant samples taken while ready.
  int m_age = 0;
  int m_low = 0;
  bit m_lat = 1'b0;

  function automatic bit m_ready(int age);
    return age >= S + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_age <= 0; m_low <= 0; m_lat <= 1'b0;
    end else begin
      if (txd_i) begin
        m_low <= 0; m_lat <= 1'b0;
      end else if (m_ready(m_age)) begin
        if (m_low == T - 1) m_lat <= 1'b1;
        m_low <= m_low + 1;
      end else begin
        m_low <= 0;
      end
      m_age <= run_req_i ? ((m_age > S + 1) ? m_age : m_age + 1) : 0;
    end
  end

  function automatic bit e_drv();
    return rst_n && m_ready(m_age) && !m_lat;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    @(negedge clk);
    chk({tag, " drv_en"}, drv_en_o, e_drv());
    chk({tag, " R4 tx_dom"}, tx_dom_o, e_drv() && !txd_i);
    chk({tag, " R7 link"}, link_ready_o, e_drv() && !uv_io_i && !uv_buf_i);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: outputs inactive under reset
    @(negedge clk);
    chk("R1 drv_en", drv_en_o, 1'b0);
    chk("R1 link", link_ready_o, 1'b0);
    chk("R1 tx_dom", tx_dom_o, 1'b0);
    rst_n = 1'b1;
    step("R1");
    // R3 and R8: startup with dominant input ignored
    run_req_i = 1'b1; txd_i = 1'b0;
    for (int i = 0; i < S; i++) begin
      step("R3");
      chk("R8 no early enable", drv_en_o, 1'b0);
    end
    step("R3");
    chk("R3 enabled after S+1 samples", drv_en_o, 1'b1);
    // R5: stuck dominant trips at exactly T samples
    for (int i = 0; i < T - 1; i++) step("R5");
    chk("R5 still enabled before limit", drv_en_o, 1'b1);
    step("R5");
    chk("R5 tripped", drv_en_o, 1'b0);
    // R6: stays off while dominant, saturating counter
    for (int i = 0; i < 3 * T; i++) step("R6");
    chk("R6 held off", drv_en_o, 1'b0);
    txd_i = 1'b1;
    step("R6");
    chk("R6 recovered", drv_en_o, 1'b1);
    // R7: undervoltage gating
    uv_io_i = 1'b1; step("R7"); chk("R7 io", link_ready_o, 1'b0);
    uv_io_i = 1'b0; uv_buf_i = 1'b1; step("R7"); chk("R7 buf", link_ready_o, 1'b0);
    uv_buf_i = 1'b0; step("R7"); chk("R7 clear", link_ready_o, 1'b1);
    // R2: sleep request
    run_req_i = 1'b0; step("R2");
    chk("R2 drv off", drv_en_o, 1'b0);
    chk("R2 link off", link_ready_o, 1'b0);
    // Random phase
    begin
      int run_left = 0;
      for (int c = 0; c < 4000; c++) begin
        if (run_left == 0) begin
          txd_i = ~txd_i;
          run_left = 1 + ($urandom % 20);
        end
        run_left--;
        if (($urandom % 150) == 0) run_req_i = ~run_req_i;
        if (($urandom % 300) == 0) run_req_i = 1'b1;
        uv_io_i  = (($urandom % 40) == 0);
        uv_buf_i = (($urandom % 40) == 0);
        step("R2 R3 R5 R6 R8 rnd");
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule